// File: doc/BRIEF.md
# Signed Word-by-Halfword Divider Unit

This execution unit divides a signed word dividend by a signed halfword divisor. It returns a word quotient, a word remainder and a new set of condition flags. A caller raises `start` for one cycle with the operands and the incoming flag state. While the unit works, `busy` stays high. In the cycle that `done` pulses, the results, the write enables and the flags are all valid.

Only the low `HW` bits of the divisor operand count, and the unit sign-extends them. The core runs a restoring loop on operand magnitudes, one quotient bit per clock, and fixes the signs at the end. Two cases are found while the operands are still at the inputs and finish after one cycle: a divisor of zero, and the most negative dividend divided by minus one. The caller also flags whether the quotient and remainder go to the same register. In that case only the remainder write is enabled.

Top module: `sdiv_wh_unit`

## Requirements
- R1: The divisor is `divisor_op[HW-1:0]` read as a two's-complement number and sign-extended. Bits `divisor_op[DW-1:HW]` have no effect on any output.
- R2: In normal cases the quotient is rounded toward zero and `dividend = quot*divisor + rem`. The remainder is zero or has the dividend's sign, and its magnitude is smaller than the divisor's.
- R3: In normal cases `s_out` equals the quotient's MSB and `z_out` is set exactly when the quotient is zero. The remainder plays no part in either flag.
- R4: In normal cases `ov_out` is 0.
- R5: With a zero divisor, `ov_out` is 1, neither write enable rises, `s_out`/`z_out` equal the latched `s_in`/`z_in`, and `done` comes 1 cycle after the start is accepted.
- R6: A dividend of only the MSB set (most negative) with divisor -1 gives `quot` equal to that dividend, `rem` 0, `ov_out`=1, `s_out`=1, `z_out`=0. Both results are written, and `done` comes 1 cycle after the start is accepted.
- R7: `cy_out` and `sat_out` equal the `cy_in` and `sat_in` latched at start, in every case.
- R8: With `same_dest`=1 and a nonzero divisor, `done` comes with `rem_we`=1 and `quot_we`=0. With `same_dest`=0, both are 1.
- R9: A normal divide raises `done` DW+1 cycles after the start is accepted. `done` lasts one cycle. `busy` is high from the cycle after acceptance through the `done` cycle. `quot_we` and `rem_we` are high only while `done` is high.
- R10: A `start` while `busy` is high is ignored. It does not change the running result and does not produce an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a divide; accepted only when idle |
| dividend | input | DW | Signed dividend |
| divisor_op | input | DW | Divisor operand; low HW bits used |
| same_dest | input | 1 | Quotient and remainder name one register |
| s_in | input | 1 | Incoming sign flag |
| z_in | input | 1 | Incoming zero flag |
| cy_in | input | 1 | Incoming carry flag |
| sat_in | input | 1 | Incoming saturation flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | DW | Quotient (zero when done is low) |
| rem | output | DW | Remainder (zero when done is low) |
| quot_we | output | 1 | Quotient write enable |
| rem_we | output | 1 | Remainder write enable |
| s_out | output | 1 | New sign flag |
| z_out | output | 1 | New zero flag |
| ov_out | output | 1 | New overflow flag |
| cy_out | output | 1 | Carry flag, passed through |
| sat_out | output | 1 | Saturation flag, passed through |

## Verification
The bench uses a reduced 8-bit dividend and a 4-bit divisor field and sweeps every dividend against every divisor nibble. The upper divisor bits take a varying junk pattern, so any use of them shows up as a wrong result (R1). Bench integer division gives the expected quotient and remainder. Sign combinations, a zero dividend and quotients of zero separate the sign-correction paths and the flag sources. The zero-divisor nibble and the most-negative-by-minus-one pair separate the one-cycle special paths from the iterative one, both in value and in latency. The `same_dest` bit and the incoming flags vary across the sweep. Directed runs add a second `start` in the middle of a divide.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sdiv_state_e;

  typedef enum logic [1:0] {
    CL_NORM = 2'd0,
    CL_ZERO = 2'd1,
    CL_OVF  = 2'd2
  } sdiv_class_e;

  typedef struct packed {
    logic sat;
    logic cy;
    logic ov;
    logic s;
    logic z;
  } sdiv_flags_t;

endpackage

// File: rtl/sdiv_classify.sv
module sdiv_classify
  import sdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input  logic [DW-1:0] num,
  input  logic [HW-1:0] den_field,
  output logic [DW-1:0] num_mag,
  output logic [DW-1:0] den_mag,
  output logic          num_neg,
  output logic          den_neg,
  output sdiv_class_e   cls
);
  localparam int EXT = DW - HW;
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  function automatic logic [DW-1:0] widen(input logic [HW-1:0] f);
    return {{EXT{f[HW-1]}}, f};
  endfunction

  function automatic logic [DW-1:0] magnitude(input logic [DW-1:0] v);
    return v[DW-1] ? (~v + 1'b1) : v;
  endfunction

  logic [DW-1:0] den_wide;

  always_comb begin
    den_wide = widen(den_field);
    num_neg  = num[DW-1];
    den_neg  = den_wide[DW-1];
    num_mag  = magnitude(num);
    den_mag  = magnitude(den_wide);
    if (den_wide == '0)
      cls = CL_ZERO;
    else if (num == MOST_NEG && den_wide == ALL_ONES)
      cls = CL_OVF;
    else
      cls = CL_NORM;
  end

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_en,
  input  logic [DW-1:0] num_mag,
  input  logic [DW-1:0] den_mag,
  output logic          last,
  output logic [DW-1:0] q_mag,
  output logic [DW-1:0] r_mag
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DW - 1);

  logic [DW-1:0] q_r, r_r, d_r;
  logic [CW-1:0] cnt_r;

  // One restoring step: shift the partial remainder in, subtract if it fits.
  function automatic logic [2*DW-1:0] div_step(input logic [DW-1:0] r_i,
                                               input logic [DW-1:0] q_i,
                                               input logic [DW-1:0] d_i);
    logic [DW:0] r_sh;
    logic        fits;
    r_sh = {r_i, q_i[DW-1]};
    fits = (r_sh >= {1'b0, d_i});
    if (fits) r_sh = r_sh - {1'b0, d_i};
    return {r_sh[DW-1:0], q_i[DW-2:0], fits};
  endfunction

  logic [2*DW-1:0] nxt;
  assign nxt = div_step(r_r, q_r, d_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      r_r   <= '0;
      d_r   <= '0;
      cnt_r <= '0;
    end else if (load) begin
      q_r   <= num_mag;
      r_r   <= '0;
      d_r   <= den_mag;
      cnt_r <= CNT_TOP;
    end else if (step_en) begin
      r_r   <= nxt[2*DW-1:DW];
      q_r   <= nxt[DW-1:0];
      cnt_r <= cnt_r - 1'b1;
    end
  end

  assign last  = (cnt_r == '0);
  assign q_mag = q_r;
  assign r_mag = r_r;

endmodule

// File: rtl/sdiv_resolve.sv
module sdiv_resolve
  import sdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          active,
  input  sdiv_class_e   cls,
  input  logic [DW-1:0] q_mag,
  input  logic [DW-1:0] r_mag,
  input  logic          num_neg,
  input  logic          den_neg,
  input  logic          same_dest,
  input  logic          s_in,
  input  logic          z_in,
  input  logic          cy_in,
  input  logic          sat_in,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem,
  output logic          quot_we,
  output logic          rem_we,
  output sdiv_flags_t   flags
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] apply_sign(input logic [DW-1:0] m, input logic neg);
    return neg ? (~m + 1'b1) : m;
  endfunction

  logic [DW-1:0] q_val, r_val;

  always_comb begin
    flags.cy  = cy_in;
    flags.sat = sat_in;
    case (cls)
      CL_ZERO: begin
        q_val   = '0;
        r_val   = '0;
        flags.ov = 1'b1;
        flags.s  = s_in;
        flags.z  = z_in;
      end
      CL_OVF: begin
        q_val   = MOST_NEG;
        r_val   = '0;
        flags.ov = 1'b1;
        flags.s  = 1'b1;
        flags.z  = 1'b0;
      end
      default: begin
        q_val   = apply_sign(q_mag, num_neg ^ den_neg);
        r_val   = apply_sign(r_mag, num_neg);
        flags.ov = 1'b0;
        flags.s  = q_val[DW-1];
        flags.z  = (q_val == '0);
      end
    endcase
    rem_we  = active && (cls != CL_ZERO);
    quot_we = rem_we && !same_dest;
    quot    = active ? q_val : '0;
    rem     = active ? r_val : '0;
  end

endmodule

// File: rtl/sdiv_wh_unit.sv
module sdiv_wh_unit
  import sdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor_op,
  input  logic          same_dest,
  input  logic          s_in,
  input  logic          z_in,
  input  logic          cy_in,
  input  logic          sat_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem,
  output logic          quot_we,
  output logic          rem_we,
  output logic          s_out,
  output logic          z_out,
  output logic          ov_out,
  output logic          cy_out,
  output logic          sat_out
);
  sdiv_state_e st_q;
  sdiv_class_e cls_now, cls_q;
  logic [DW-1:0] num_mag, den_mag, q_mag, r_mag;
  logic num_neg, den_neg, nneg_q, dneg_q, same_q;
  logic s_q, z_q, cy_q, sat_q;
  logic core_last;
  sdiv_flags_t flg;

  // Named internal events for the checker
  logic ev_accept, ev_div_zero, ev_ovf, ev_last_step;
  assign ev_accept    = start && (st_q == ST_IDLE);
  assign ev_div_zero  = (cls_q == CL_ZERO);
  assign ev_ovf       = (cls_q == CL_OVF);
  assign ev_last_step = (st_q == ST_RUN) && core_last;

  sdiv_classify #(.DW(DW), .HW(HW)) classify_i (
    .num       (dividend),
    .den_field (divisor_op[HW-1:0]),
    .num_mag   (num_mag),
    .den_mag   (den_mag),
    .num_neg   (num_neg),
    .den_neg   (den_neg),
    .cls       (cls_now)
  );

  sdiv_core #(.DW(DW)) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_accept),
    .step_en (st_q == ST_RUN),
    .num_mag (num_mag),
    .den_mag (den_mag),
    .last    (core_last),
    .q_mag   (q_mag),
    .r_mag   (r_mag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cls_q  <= CL_NORM;
      nneg_q <= 1'b0;
      dneg_q <= 1'b0;
      same_q <= 1'b0;
      s_q    <= 1'b0;
      z_q    <= 1'b0;
      cy_q   <= 1'b0;
      sat_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (ev_accept) begin
          st_q   <= (cls_now == CL_NORM) ? ST_RUN : ST_DONE;
          cls_q  <= cls_now;
          nneg_q <= num_neg;
          dneg_q <= den_neg;
          same_q <= same_dest;
          s_q    <= s_in;
          z_q    <= z_in;
          cy_q   <= cy_in;
          sat_q  <= sat_in;
        end
        ST_RUN:  if (ev_last_step) st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_DONE);

  sdiv_resolve #(.DW(DW)) resolve_i (
    .active    (done),
    .cls       (cls_q),
    .q_mag     (q_mag),
    .r_mag     (r_mag),
    .num_neg   (nneg_q),
    .den_neg   (dneg_q),
    .same_dest (same_q),
    .s_in      (s_q),
    .z_in      (z_q),
    .cy_in     (cy_q),
    .sat_in    (sat_q),
    .quot      (quot),
    .rem       (rem),
    .quot_we   (quot_we),
    .rem_we    (rem_we),
    .flags     (flg)
  );

  assign s_out   = flg.s;
  assign z_out   = flg.z;
  assign ov_out  = flg.ov;
  assign cy_out  = flg.cy;
  assign sat_out = flg.sat;

endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] quot,
  input logic [DW-1:0] rem,
  input logic          quot_we,
  input logic          rem_we,
  input logic          s_out,
  input logic          z_out,
  input logic          ov_out,
  input logic          cy_out,
  input logic          sat_out,
  input logic [DW-1:0] dividend,
  input logic [HW-1:0] den_field,
  input logic          same_dest,
  input logic          s_in,
  input logic          z_in,
  input logic          cy_in,
  input logic          sat_in,
  input logic          ev_accept,
  input logic          ev_div_zero,
  input logic          ev_ovf
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] absv(input logic [DW-1:0] v);
    return v[DW-1] ? (~v + 1'b1) : v;
  endfunction

  logic [DW-1:0] c_num, c_den;
  logic c_same, c_s, c_z, c_cy, c_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_num <= '0; c_den <= '0; c_same <= 1'b0;
      c_s <= 1'b0; c_z <= 1'b0; c_cy <= 1'b0; c_sat <= 1'b0;
    end else if (ev_accept) begin
      c_num  <= dividend;
      c_den  <= {{(DW-HW){den_field[HW-1]}}, den_field};
      c_same <= same_dest;
      c_s <= s_in; c_z <= z_in; c_cy <= cy_in; c_sat <= sat_in;
    end
  end

  // R2: remainder bounded by the divisor and carries the dividend's sign
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ov_out) |-> (absv(rem) < absv(c_den)));
  p_rem_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ov_out) |-> (rem == '0 || rem[DW-1] == c_num[DW-1]));
  // R3: flags follow the quotient
  p_sz_quot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ov_out) |-> (s_out == quot[DW-1] && z_out == (quot == '0)));
  // R4: overflow only for the two special classes
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ov_out) |-> (ev_div_zero || ev_ovf));
  // R5: zero divisor writes nothing and keeps S/Z
  p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ev_div_zero) |-> (!quot_we && !rem_we && ov_out && s_out == c_s && z_out == c_z));
  p_zero_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && den_field == '0) |=> done);
  // R6: most-negative by minus one
  p_ovf_vals_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ev_ovf) |-> (quot == MOST_NEG && rem == '0 && ov_out && s_out && !z_out && rem_we));
  // R7: carry and saturation pass through
  p_flag_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cy_out == c_cy && sat_out == c_sat));
  // R8: same destination keeps only the remainder write
  p_same_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ev_div_zero) |-> (rem_we && (quot_we == !c_same)));
  // R9: handshake shape
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_we_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quot_we || rem_we) |-> done);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R10: busy only rises from an accepted start
  p_busy_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_accept));

endmodule

bind sdiv_wh_unit sdiv_chk #(.DW(DW), .HW(HW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .quot        (quot),
  .rem         (rem),
  .quot_we     (quot_we),
  .rem_we      (rem_we),
  .s_out       (s_out),
  .z_out       (z_out),
  .ov_out      (ov_out),
  .cy_out      (cy_out),
  .sat_out     (sat_out),
  .dividend    (dividend),
  .den_field   (divisor_op[HW-1:0]),
  .same_dest   (same_dest),
  .s_in        (s_in),
  .z_in        (z_in),
  .cy_in       (cy_in),
  .sat_in      (sat_in),
  .ev_accept   (ev_accept),
  .ev_div_zero (ev_div_zero),
  .ev_ovf      (ev_ovf)
);

// File: tb/sdiv_wh_unit_tb.sv
module sdiv_wh_unit_tb_top;
  localparam int DW = 8;
  localparam int HW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [DW-1:0] divisor_op = '0;
  logic same_dest = 1'b0;
  logic s_in = 1'b0, z_in = 1'b0, cy_in = 1'b0, sat_in = 1'b0;
  logic busy, done, quot_we, rem_we, s_out, z_out, ov_out, cy_out, sat_out;
  logic [DW-1:0] quot, rem;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  sdiv_wh_unit #(.DW(DW), .HW(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor_op(divisor_op), .same_dest(same_dest), .s_in(s_in), .z_in(z_in),
    .cy_in(cy_in), .sat_in(sat_in), .busy(busy), .done(done), .quot(quot),
    .rem(rem), .quot_we(quot_we), .rem_we(rem_we), .s_out(s_out), .z_out(z_out),
    .ov_out(ov_out), .cy_out(cy_out), .sat_out(sat_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Runs one divide; if intrude, raises start again mid-run with other operands.
  task automatic run_op(input logic [DW-1:0] a_op, input logic [DW-1:0] d_op,
                        input bit same, input logic [3:0] fl, input bit intrude);
    int a, d, eq, er, n, exp_lat;
    bit zero_c, ovf_c;
    logic [DW-1:0] eq_b, er_b;
    a = int'($signed(a_op));
    d = int'($signed(d_op[HW-1:0]));
    zero_c = (d == 0);
    ovf_c  = (a == -(1 << (DW-1))) && (d == -1);
    if (zero_c) begin eq = 0; er = 0; end
    else if (ovf_c) begin eq = a; er = 0; end
    else begin eq = a / d; er = a % d; end
    eq_b = eq[DW-1:0];
    er_b = er[DW-1:0];
    exp_lat = (zero_c || ovf_c) ? 1 : DW + 1;

    @(negedge clk);
    dividend = a_op; divisor_op = d_op; same_dest = same;
    {sat_in, cy_in, z_in, s_in} = fl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 3 * DW) begin
      if (intrude && n == 3) begin
        start = 1'b1;
        dividend = ~a_op; divisor_op = d_op ^ 8'h03; same_dest = ~same;
        {sat_in, cy_in, z_in, s_in} = ~fl;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == exp_lat, zero_c ? "R5" : (ovf_c ? "R6" : "R9"), "latency", n, exp_lat);
    check(done == 1'b1, "R9", "done", int'(done), 1);
    if (!zero_c) begin
      check(quot == eq_b, ovf_c ? "R6" : "R2", "quot", int'(quot), int'(eq_b));
      check(rem == er_b, ovf_c ? "R6" : "R2", "rem", int'(rem), int'(er_b));
    end
    if (zero_c) begin
      check(ov_out == 1'b1, "R5", "ov", int'(ov_out), 1);
      check({s_out, z_out} == {fl[0], fl[1]}, "R5", "s,z kept",
            int'({s_out, z_out}), int'({fl[0], fl[1]}));
      check({quot_we, rem_we} == 2'b00, "R5", "we", int'({quot_we, rem_we}), 0);
    end else if (ovf_c) begin
      check({ov_out, s_out, z_out} == 3'b110, "R6", "ov,s,z",
            int'({ov_out, s_out, z_out}), 6);
    end else begin
      check(ov_out == 1'b0, "R4", "ov", int'(ov_out), 0);
      check({s_out, z_out} == {eq < 0, eq == 0}, "R3", "s,z",
            int'({s_out, z_out}), int'({eq < 0, eq == 0}));
    end
    if (!zero_c)
      check({quot_we, rem_we} == {!same, 1'b1}, "R8", "we",
            int'({quot_we, rem_we}), int'({!same, 1'b1}));
    check({sat_out, cy_out} == fl[3:2], "R7", "cy,sat", int'({sat_out, cy_out}), int'(fl[3:2]));
    @(negedge clk);
    check({done, busy, quot_we, rem_we} == 4'b0000, "R9", "after done",
          int'({done, busy, quot_we, rem_we}), 0);
    if (intrude) begin
      @(negedge clk);
      check({done, busy} == 2'b00, "R10", "no second op", int'({done, busy}), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, quot_we, rem_we} == 4'b0000, "R9", "reset state",
          int'({busy, done, quot_we, rem_we}), 0);
    rst_n = 1'b1;

    // Directed sign and special cases
    run_op(8'd45, 8'h06, 1'b0, 4'h0, 1'b0);
    run_op(8'd45, 8'hFA, 1'b0, 4'h0, 1'b0);   // R1: upper bits set, low nibble -6
    run_op(8'd45, 8'h3A, 1'b0, 4'h0, 1'b0);   // R1: different upper bits, same result
    run_op(-8'sd45, 8'h06, 1'b0, 4'h5, 1'b0);
    run_op(-8'sd45, 8'h0A, 1'b1, 4'hA, 1'b0);
    run_op(8'd0, 8'h05, 1'b0, 4'h0, 1'b0);
    run_op(8'd5, 8'h07, 1'b0, 4'h0, 1'b0);    // R3: zero quotient, nonzero remainder
    run_op(8'd45, 8'hF0, 1'b0, 4'hF, 1'b0);   // R5: zero divisor, all flags in set
    run_op(8'd45, 8'h00, 1'b1, 4'h0, 1'b0);   // R5
    run_op(8'h80, 8'hFF, 1'b0, 4'h0, 1'b0);   // R6
    run_op(8'h80, 8'h0F, 1'b1, 4'hC, 1'b0);   // R6 with R8
    run_op(8'd100, 8'h03, 1'b0, 4'h6, 1'b1);  // R10
    run_op(-8'sd128, 8'h05, 1'b1, 4'h9, 1'b1); // R10

    // Exhaustive sweep, upper divisor bits as junk (R1)
    for (int a = 0; a < (1 << DW); a++) begin
      for (int b = 0; b < (1 << HW); b++) begin
        logic [DW-1:0] dop;
        dop = {4'((a ^ (b * 3)) & 15), 4'(b)};
        run_op(8'(a), dop, ((a + b) % 5) == 0, 4'((a + 2 * b) % 16), 1'b0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule